// File: doc/BRIEF.md
# Framed 32-bit Message Link

This block carries whole messages of 32-bit words across a point-to-point channel made of a forwarded clock, one data-enable strobe and a 32-bit data bus. One word travels in every clock while a message is on the wire. Message boundaries are carried by strobe edges, not by a level. The strobe goes high together with the first word. It goes low together with the last word, so that word is sent while the strobe is low. A new message may begin in the very next cycle, and the strobe then rises again.

The transmit half takes messages from a valid/ready stream, with a last-word marker on the final word. It stores each message completely in one of two banks before sending it. While one bank is on the wire, the other bank fills. This lets two stored messages leave back to back with no idle cycle between them. Messages shorter than two words are padded, and messages that are too long are truncated.

The receive half watches the strobe and data on its own pins. It outputs every word one cycle later, with start and end markers. It flags a message whose length is outside the allowed range. After reset it discards any fragment that is already in flight.

Top module: `msg_link`

The transmit half has two named states. TX_IDLE moves to TX_SEND on "bank ready", which starts the first word. TX_SEND moves back to TX_IDLE on "last word out".

The receive half has three named states. RX_HUNT moves to RX_IDLE on "strobe low". RX_IDLE moves to RX_OPEN on "strobe high", which is the first word. RX_OPEN moves back to RX_IDLE on "strobe low", which is the last word.

## Requirements
- R1: The transmitter drives `link_en_o` high in the same cycle as the first word of every message. Words leave one per clock, in input order, on `link_data_o`.
- R2: The transmitter drives `link_en_o` low in the cycle that carries the last word of a message. The strobe is high for every earlier word of that message.
- R3: If the next message is already fully stored when a message's last word leaves, the first word of the next message is sent in the following cycle.
- R4: When no message is being sent, `link_en_o` is low and `link_data_o` is zero.
- R5: A message starts only after its last word has been accepted. No idle cycle is placed inside a message, so the strobe is never high for more than TX_MAX_WORDS-1 cycles in a row.
- R6: A one-word request is sent as two words. The second word is zero.
- R7: A request longer than TX_MAX_WORDS words is accepted in full, but only its first TX_MAX_WORDS words are sent.
- R8: For every link cycle with the strobe high, or with the strobe low while a message is open, the receiver raises `rx_valid` one cycle later. `rx_data` equals the sampled word. `rx_sop` marks the word where the strobe rose from idle, and `rx_eop` marks the word where the strobe was low.
- R9: `rx_len_err` is raised together with `rx_eop` exactly when the message length is greater than RX_MAX_WORDS or less than RX_MIN_WORDS.
- R10: If the strobe is high when reset ends, the receiver outputs no words until the strobe is low. At that point it raises `rx_frame_err` for one cycle and then waits for a rising edge.
- R11: Right after reset, `in_ready` is 1, `link_en_o` is 0, and `rx_valid`, `rx_len_err` and `rx_frame_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transmit word offered |
| in_ready | output | 1 | Transmit word can be taken |
| in_data | input | 32 | Transmit word |
| in_last | input | 1 | Offered word ends the message |
| link_en_o | output | 1 | Outgoing data-enable strobe |
| link_data_o | output | 32 | Outgoing link word |
| link_en_i | input | 1 | Incoming data-enable strobe |
| link_data_i | input | 32 | Incoming link word |
| rx_valid | output | 1 | Received word present |
| rx_data | output | 32 | Received word |
| rx_sop | output | 1 | First word of a message |
| rx_eop | output | 1 | Last word of a message |
| rx_len_err | output | 1 | Length out of range, valid with rx_eop |
| rx_frame_err | output | 1 | One-cycle pulse when a fragment found after reset is dropped |

## Verification
The transmit half is looped back to the receive half, and messages are sent that tell the length handling apart.

- Lengths of 1 and 2 words separate padding from plain delivery.
- Lengths of 16 and 20 words separate full-length delivery from truncation.
- Random lengths, with random pauses in the input stream, show whether a stall inside a request can split a message on the wire.

A pair of messages queued with no pause tells back-to-back sending apart from sending with an idle cycle between them.

With the link pins driven directly, further patterns are applied:

- frames of 16 and 17 words sit on either side of the length-error limit;
- frames sent back to back check that the receiver re-opens on the cycle right after an end;
- holding the strobe high through reset tests the fragment discard.

// File: rtl/msg_link_pkg.sv
package msg_link_pkg;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_IDLE,
        RX_OPEN
    } rx_state_t;

endpackage

// File: rtl/msg_link_txbuf.sv
// Two-bank message store: one bank fills from the input stream while the
// other is read by the sender. Banks are filled and drained in turn.
module msg_link_txbuf #(
    parameter  int DATA_W    = 32,
    parameter  int MAX_WORDS = 16,
    localparam int IDX_W     = $clog2(MAX_WORDS),
    localparam int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [DATA_W-1:0]        in_data,
    input  logic                     in_last,
    input  logic                     rd_bank,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     release_i,
    output logic [1:0]               full_o,
    output logic [1:0][CNT_W-1:0]    cnt_o
);

    localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_WORDS);

    logic                  fill_bank;
    logic [CNT_W-1:0]      wcnt;
    logic [1:0]            full_q;
    logic [1:0][CNT_W-1:0] cnt_q;
    logic                  accept;
    logic                  room;
    logic [DATA_W-1:0]     bank_rd [2];

    assign in_ready = !full_q[fill_bank];
    assign accept   = in_valid && in_ready;
    assign room     = wcnt < MAXC;

    // Fill pointer, word counter, per-bank length and full flags
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_bank <= 1'b0;
            wcnt      <= '0;
            full_q    <= '0;
            cnt_q     <= '0;
        end else begin
            if (release_i) begin
                full_q[rd_bank] <= 1'b0;
            end
            if (accept) begin
                if (room) begin
                    wcnt <= wcnt + CNT_W'(1);
                end
                if (in_last) begin
                    full_q[fill_bank] <= 1'b1;
                    cnt_q[fill_bank]  <= room ? wcnt + CNT_W'(1) : MAXC;
                    fill_bank         <= ~fill_bank;
                    wcnt              <= '0;
                end
            end
        end
    end

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            logic [DATA_W-1:0] mem [MAX_WORDS];

            always_ff @(posedge clk) begin
                if (accept && room && (fill_bank == 1'(b))) begin
                    mem[wcnt[IDX_W-1:0]] <= in_data;
                end
            end

            assign bank_rd[b] = mem[rd_idx];
        end
    endgenerate

    assign rd_data = bank_rd[rd_bank];
    assign full_o  = full_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/msg_link_tx.sv
// Sender: walks a stored bank onto the link, strobe high for all but the
// final word, and goes straight to the next bank when it is ready.
module msg_link_tx
    import msg_link_pkg::*;
#(
    parameter  int DATA_W    = 32,
    parameter  int MAX_WORDS = 16,
    localparam int IDX_W     = $clog2(MAX_WORDS),
    localparam int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            full_i,
    input  logic [1:0][CNT_W-1:0] cnt_i,
    output logic                  rd_bank_o,
    output logic [IDX_W-1:0]      rd_idx_o,
    input  logic [DATA_W-1:0]     rd_data_i,
    output logic                  release_o,
    output logic                  link_en_o,
    output logic [DATA_W-1:0]     link_data_o
);

    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    tx_state_t         state_q;
    tx_state_t         state_d;
    logic              send_bank;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  cur_cnt;
    logic [CNT_W-1:0]  cur_len;
    logic              is_last;
    logic              bank_ready;
    logic [DATA_W-1:0] word;

    assign cur_cnt    = cnt_i[send_bank];
    assign cur_len    = (cur_cnt < TWO) ? TWO : cur_cnt;
    assign is_last    = (idx == cur_len - CNT_W'(1));
    assign bank_ready = full_i[send_bank];
    assign word       = (idx < cur_cnt) ? rd_data_i : '0;
    assign rd_bank_o  = send_bank;
    assign rd_idx_o   = idx[IDX_W-1:0];
    assign release_o  = (state_q == TX_SEND) && is_last;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: bank ready, last word out
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (bank_ready) state_d = TX_SEND;
            TX_SEND: if (is_last)    state_d = TX_IDLE;
        endcase
    end

    // Outputs and word index
    always_ff @(posedge clk) begin
        if (rst) begin
            link_en_o   <= 1'b0;
            link_data_o <= '0;
            idx         <= '0;
            send_bank   <= 1'b0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (bank_ready) begin
                        link_en_o   <= 1'b1;
                        link_data_o <= word;
                        idx         <= CNT_W'(1);
                    end else begin
                        link_en_o   <= 1'b0;
                        link_data_o <= '0;
                    end
                end
                TX_SEND: begin
                    link_data_o <= word;
                    link_en_o   <= !is_last;
                    if (is_last) begin
                        idx       <= '0;
                        send_bank <= ~send_bank;
                    end else begin
                        idx <= idx + CNT_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/msg_link_rx.sv
// Receiver: opens a message on a rising strobe, closes it on the word that
// arrives with the strobe low, and checks the word count.
module msg_link_rx
    import msg_link_pkg::*;
#(
    parameter  int DATA_W    = 32,
    parameter  int MIN_WORDS = 2,
    parameter  int MAX_WORDS = 16,
    localparam int CNT_W     = $clog2(MAX_WORDS + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_en_i,
    input  logic [DATA_W-1:0] link_data_i,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_sop,
    output logic              rx_eop,
    output logic              rx_len_err,
    output logic              rx_frame_err
);

    localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_WORDS);
    localparam logic [CNT_W-1:0] MINC = CNT_W'(MIN_WORDS);

    rx_state_t        state_q;
    rx_state_t        state_d;
    logic [CNT_W-1:0] cnt;
    logic             junk;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: strobe low ends hunt, strobe high opens, strobe low closes
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HUNT: if (!link_en_i) state_d = RX_IDLE;
            RX_IDLE: if (link_en_i)  state_d = RX_OPEN;
            RX_OPEN: if (!link_en_i) state_d = RX_IDLE;
            default: state_d = RX_HUNT;
        endcase
    end

    // Outputs, word count and fragment flag
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid     <= 1'b0;
            rx_data      <= '0;
            rx_sop       <= 1'b0;
            rx_eop       <= 1'b0;
            rx_len_err   <= 1'b0;
            rx_frame_err <= 1'b0;
            cnt          <= '0;
            junk         <= 1'b0;
        end else begin
            rx_valid     <= 1'b0;
            rx_sop       <= 1'b0;
            rx_eop       <= 1'b0;
            rx_len_err   <= 1'b0;
            rx_frame_err <= 1'b0;
            unique case (state_q)
                RX_HUNT: begin
                    if (link_en_i) begin
                        junk <= 1'b1;
                    end else begin
                        rx_frame_err <= junk;
                        junk         <= 1'b0;
                    end
                end
                RX_IDLE: begin
                    if (link_en_i) begin
                        rx_valid <= 1'b1;
                        rx_sop   <= 1'b1;
                        rx_data  <= link_data_i;
                        cnt      <= CNT_W'(1);
                    end
                end
                RX_OPEN: begin
                    rx_valid <= 1'b1;
                    rx_data  <= link_data_i;
                    if (link_en_i) begin
                        if (cnt <= MAXC) cnt <= cnt + CNT_W'(1);
                    end else begin
                        rx_eop     <= 1'b1;
                        rx_len_err <= (cnt >= MAXC) || ((cnt + CNT_W'(1)) < MINC);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/msg_link.sv
module msg_link #(
    parameter int DATA_W       = 32,
    parameter int TX_MAX_WORDS = 16,
    parameter int RX_MIN_WORDS = 2,
    parameter int RX_MAX_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              link_en_o,
    output logic [DATA_W-1:0] link_data_o,
    input  logic              link_en_i,
    input  logic [DATA_W-1:0] link_data_i,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_sop,
    output logic              rx_eop,
    output logic              rx_len_err,
    output logic              rx_frame_err
);

    localparam int IDX_W = $clog2(TX_MAX_WORDS);
    localparam int CNT_W = $clog2(TX_MAX_WORDS + 1);

    logic                  rd_bank;
    logic [IDX_W-1:0]      rd_idx;
    logic [DATA_W-1:0]     rd_data;
    logic                  release_b;
    logic [1:0]            full_b;
    logic [1:0][CNT_W-1:0] cnt_b;

    msg_link_txbuf #(
        .DATA_W    (DATA_W),
        .MAX_WORDS (TX_MAX_WORDS)
    ) u_txbuf (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .rd_bank   (rd_bank),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .release_i (release_b),
        .full_o    (full_b),
        .cnt_o     (cnt_b)
    );

    msg_link_tx #(
        .DATA_W    (DATA_W),
        .MAX_WORDS (TX_MAX_WORDS)
    ) u_tx (
        .clk         (clk),
        .rst         (rst),
        .full_i      (full_b),
        .cnt_i       (cnt_b),
        .rd_bank_o   (rd_bank),
        .rd_idx_o    (rd_idx),
        .rd_data_i   (rd_data),
        .release_o   (release_b),
        .link_en_o   (link_en_o),
        .link_data_o (link_data_o)
    );

    msg_link_rx #(
        .DATA_W    (DATA_W),
        .MIN_WORDS (RX_MIN_WORDS),
        .MAX_WORDS (RX_MAX_WORDS)
    ) u_rx (
        .clk          (clk),
        .rst          (rst),
        .link_en_i    (link_en_i),
        .link_data_i  (link_data_i),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_sop       (rx_sop),
        .rx_eop       (rx_eop),
        .rx_len_err   (rx_len_err),
        .rx_frame_err (rx_frame_err)
    );

endmodule

// File: rtl/msg_link_chk.sv
module msg_link_chk #(
    parameter int DATA_W       = 32,
    parameter int TX_MAX_WORDS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              link_en_o,
    input logic              link_en_i,
    input logic [DATA_W-1:0] link_data_i,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_sop,
    input logic              rx_eop,
    input logic              rx_len_err,
    input logic              rx_frame_err
);

    localparam int HW = $clog2(TX_MAX_WORDS + 1);

    // Consecutive high-strobe cycles seen before the current one
    logic [HW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else if (link_en_o) begin
            hi_run <= hi_run + HW'(1);
        end else begin
            hi_run <= '0;
        end
    end

    assert_strobe_run_R5: assert property (@(posedge clk) disable iff (rst)
        link_en_o |-> (hi_run <= HW'(TX_MAX_WORDS - 2)));

    assert_sop_rise_R8: assert property (@(posedge clk) disable iff (rst)
        rx_sop |-> (rx_valid && $past(link_en_i)));

    assert_eop_low_R2: assert property (@(posedge clk) disable iff (rst)
        rx_eop |-> (rx_valid && !$past(link_en_i)));

    assert_data_follow_R8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rx_data == $past(link_data_i)));

    assert_len_err_eop_R9: assert property (@(posedge clk) disable iff (rst)
        rx_len_err |-> rx_eop);

    assert_frame_err_alone_R10: assert property (@(posedge clk) disable iff (rst)
        rx_frame_err |-> !rx_valid);

endmodule

bind msg_link msg_link_chk #(
    .DATA_W       (DATA_W),
    .TX_MAX_WORDS (TX_MAX_WORDS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .link_en_o    (link_en_o),
    .link_en_i    (link_en_i),
    .link_data_i  (link_data_i),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_sop       (rx_sop),
    .rx_eop       (rx_eop),
    .rx_len_err   (rx_len_err),
    .rx_frame_err (rx_frame_err)
);

// File: tb/test_msg_link.sv
module test_msg_link;

    localparam int DW   = 32;
    localparam int TXM  = 16;
    localparam int RXM  = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_ready;
    logic [DW-1:0] in_data;
    logic          in_last;
    logic          link_en_o;
    logic [DW-1:0] link_data_o;
    logic          link_en_i;
    logic [DW-1:0] link_data_i;
    logic          rx_valid;
    logic [DW-1:0] rx_data;
    logic          rx_sop;
    logic          rx_eop;
    logic          rx_len_err;
    logic          rx_frame_err;

    logic          loop_mode;
    logic          drv_en;
    logic [DW-1:0] drv_data;

    always #10 clk = ~clk;

    assign link_en_i   = loop_mode ? link_en_o   : drv_en;
    assign link_data_i = loop_mode ? link_data_o : drv_data;

    msg_link #(
        .DATA_W       (DW),
        .TX_MAX_WORDS (TXM),
        .RX_MIN_WORDS (2),
        .RX_MAX_WORDS (RXM)
    ) i_msg_link (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_last      (in_last),
        .link_en_o    (link_en_o),
        .link_data_o  (link_data_o),
        .link_en_i    (link_en_i),
        .link_data_i  (link_data_i),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_sop       (rx_sop),
        .rx_eop       (rx_eop),
        .rx_len_err   (rx_len_err),
        .rx_frame_err (rx_frame_err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ferr_seen = 0;
    int last_eop_cyc = -10;
    int sop_gap = 0;
    bit finished = 0;

    // Expected receive words: {len_err, eop, sop, data}
    logic [DW+2:0] expq[$];
    logic [DW-1:0] msg [32];

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int tx_len(input int n);
        if (n < 2) return 2;
        if (n > TXM) return TXM;
        return n;
    endfunction

    function automatic logic [DW+2:0] exp_word(input logic [DW-1:0] d, input bit sop,
                                               input bit eop, input bit lerr);
        return {lerr, eop, sop, d};
    endfunction

    // Receive monitor, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (rx_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R8 unexpected received word", {29'd0, rx_len_err, rx_eop, rx_sop, rx_data}, 64'd0);
                end else begin
                    logic [DW+2:0] e;
                    e = expq.pop_front();
                    chk({rx_len_err, rx_eop, rx_sop, rx_data} == e,
                        "R1 R2 R8 R9 received word/markers",
                        {29'd0, rx_len_err, rx_eop, rx_sop, rx_data}, {29'd0, e});
                end
                if (rx_sop) sop_gap = cyc - last_eop_cyc;
                if (rx_eop) last_eop_cyc = cyc;
            end
            if (rx_frame_err) ferr_seen++;
        end
    end

    // Queue a request of n words on the transmit stream
    task automatic send(input int n, input int gap_pct);
        int l;
        l = tx_len(n);
        for (int i = 0; i < n; i++) msg[i] = $urandom;
        for (int i = 0; i < l; i++)
            expq.push_back(exp_word((i < n) ? msg[i] : '0, i == 0, i == l - 1, 1'b0));
        for (int i = 0; i < n; i++) begin
            while (($urandom % 100) < gap_pct) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = msg[i];
            in_last  = (i == n - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // Drive an n-word frame straight onto the receive pins
    task automatic drive_frame(input int n);
        bit lerr;
        lerr = (n > RXM) || (n < 2);
        for (int i = 0; i < n; i++) begin
            drv_en   = (i != n - 1);
            drv_data = $urandom;
            expq.push_back(exp_word(drv_data, i == 0, i == n - 1, (i == n - 1) && lerr));
            @(negedge clk);
        end
        drv_en = 1'b0;
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (expq.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R8 all expected words delivered", expq.size(), 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_data   = '0;
        in_last   = 1'b0;
        loop_mode = 1'b0;
        drv_en    = 1'b1;
        drv_data  = 32'hdead_0001;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 / R4: reset state
        chk(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);
        chk(link_en_o == 1'b0, "R11 R4 strobe low after reset", link_en_o, 0);
        chk(link_data_o == '0, "R4 idle data zero", link_data_o, 0);
        chk({rx_valid, rx_len_err, rx_frame_err} == 3'b000, "R11 receive flags after reset",
            {rx_valid, rx_len_err, rx_frame_err}, 0);

        // R10: fragment in flight at reset is dropped, one error pulse
        drv_data = 32'hdead_0002;
        @(negedge clk);
        drv_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(ferr_seen == 1, "R10 frame error pulses once", ferr_seen, 1);
        chk(expq.size() == 0, "R10 no words from fragment", expq.size(), 0);

        // R9 / R8: direct frames at the length limits, back to back
        drive_frame(16);
        drive_frame(17);
        chk(sop_gap == 1, "R8 receiver reopens right after an end", sop_gap, 1);
        drive_frame(2);
        repeat (2) @(negedge clk);
        drive_frame(20);
        drain();
        chk(ferr_seen == 1, "R10 no further frame errors", ferr_seen, 1);

        // Loopback phase
        loop_mode = 1'b1;
        repeat (2) @(negedge clk);

        send(1, 0);      // R6 padding
        drain();
        send(2, 0);      // R1 R2 minimum length
        drain();
        send(TXM, 0);    // full length
        drain();
        send(20, 0);     // R7 truncation
        drain();

        // R3: two messages queued without a pause
        send(4, 0);
        send(3, 0);
        drain();
        chk(sop_gap == 1, "R3 back-to-back start follows last word", sop_gap, 1);

        // R4: idle link after drain
        chk(link_en_o == 1'b0 && link_data_o == '0, "R4 idle link quiet",
            {31'd0, link_en_o, link_data_o}, 0);

        // R5: random lengths with stalls inside requests
        for (int k = 0; k < 40; k++) begin
            send(($urandom % 20) + 1, 25);
        end
        drain();
        chk(ferr_seen == 1, "R10 no frame errors in loopback", ferr_seen, 1);
        chk(in_ready == 1'b1, "R11 in_ready after all traffic", in_ready, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule